// File: doc/BRIEF.md
# Round-Robin Cache-Line Lock Arbiter

This block is the central gatekeeper for paired cache-line locks in a multi-threaded cluster. By default the cluster has sixteen cores with two hardware threads each, thirty-two threads in all. Each thread can queue up to two outstanding requests. A request either locks a pair of cache-line indices or releases a pair it holds. The arbiter keeps one bit per line in a registry, plus the identity of the thread that holds each locked line.

A rotation pointer sweeps the threads one per clock and never skips an idle thread, so every thread gets exactly one evaluation window per rotation. In its window a thread's slot 0 is judged first, then slot 1 against the registry as slot 0 left it. A lock is all-or-nothing: both lines must be free. If so, both bits are set together and the thread receives ACK. Otherwise the thread receives NACK, keeps the request, raises its stall line and is retried in its next window.

A release clears both bits only when the releasing thread holds both lines. Any other release is dropped and raises a sticky error flag.

Top module: `rr_lock_arbiter`

## Requirements
- R1: After synchronous reset all lines are unlocked, no slot is occupied, `req_rdy` is all ones, and `thr_stall`, `rsp_vld` and `err_rel` are zero.
- R2: Each thread has two slots. A request is taken at a rising edge where both `req_vld[t]` and `req_rdy[t]` are high, and it goes into the lowest free slot. `req_rdy[t]` is low while both slots are occupied, and a request offered then is not taken and has no effect on the registry.
- R3: The first edge after reset evaluates thread 0. Each later edge evaluates the next thread, wrapping after thread NUM_THR-1, whether or not that thread has work. The response of edge k appears after that edge, with `rsp_thr` = k mod NUM_THR.
- R4: In a window, slot 0 is judged before slot 1, and slot 1 sees the registry and ownership as updated by slot 0 in the same cycle. Slot-s results appear on `rsp_vld[s]`/`rsp_ack[s]`.
- R5: A lock request (`req_rel`=0) whose two lines are both unlocked sets both registry bits, records the thread as their holder, answers `rsp_ack`=1 and frees its slot. The two lines may be equal.
- R6: A lock request with either line locked, by any thread, answers `rsp_ack`=0, sets neither bit, and stays in its slot for a retry in the next window. `thr_stall[t]` is high while thread t holds such a refused slot.
- R7: A registry change made in one window is seen by the window of the next cycle.
- R8: A release request (`req_rel`=1) whose two lines are both locked and held by the requester clears both bits, answers `rsp_ack`=1 and frees its slot.
- R9: Any other release changes no registry bit, answers `rsp_ack`=0, frees its slot, and sets `err_rel`, which then stays high until reset.
- R10: With no other traffic, a thread's lock request is answered no more than NUM_THR cycles after the edge that took it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NUM_THR | Per-thread request offer |
| req_rel | input | NUM_THR | Per-thread kind: 0 lock, 1 release |
| req_line_a | input | NUM_THR*LW | First line index, thread t at bits [t*LW +: LW] |
| req_line_b | input | NUM_THR*LW | Second line index, same packing |
| req_rdy | output | NUM_THR | Thread has a free slot |
| thr_stall | output | NUM_THR | Thread holds a refused lock request |
| rsp_vld | output | 2 | Slot 0 / slot 1 of the evaluated thread was judged |
| rsp_ack | output | 2 | 1 = ACK, 0 = NACK, per slot |
| rsp_thr | output | TW | Thread judged at the last edge |
| err_rel | output | 1 | Sticky flag for an ignored release |

## Verification
A request offered before a rising edge is taken at that edge. Its answer is registered at the first later edge whose pointer value equals its thread, so it arrives one to NUM_THR cycles later, and `thr_stall` and `err_rel` change at that same edge. The bench samples only on falling edges. It derives the pointer from its own count of edges since reset, checks each response's thread against it, and uses a wait-for-pointer task where the order of two threads matters. Expected answers sit in per-thread queues; a repeated NACK for a slot already refused is accepted as a retry, and after each step of two full rotations every queue must be empty.

// File: rtl/lka_pkg.sv
package lka_pkg;
  localparam int SLOTS = 2;

  function automatic int unsigned wrap_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/lka_slots.sv
module lka_slots #(
  parameter int NUM_THR = 32,
  parameter int LW      = 6,
  parameter int TW      = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_THR-1:0]    req_vld,
  input  logic [NUM_THR-1:0]    req_rel,
  input  logic [NUM_THR*LW-1:0] req_line_a,
  input  logic [NUM_THR*LW-1:0] req_line_b,
  input  logic [TW-1:0]         ev_thr,
  input  logic [1:0]            ev_done,
  input  logic [1:0]            ev_nack,
  output logic [NUM_THR-1:0]    req_rdy,
  output logic [NUM_THR-1:0]    thr_stall,
  output logic [1:0]            ev_v,
  output logic [1:0]            ev_rel,
  output logic [2*LW-1:0]       ev_a,
  output logic [2*LW-1:0]       ev_b
);
  logic [1:0]    v_q   [NUM_THR];
  logic [1:0]    nk_q  [NUM_THR];
  logic [1:0]    rel_q [NUM_THR];
  logic [LW-1:0] a_q   [NUM_THR][lka_pkg::SLOTS];
  logic [LW-1:0] b_q   [NUM_THR][lka_pkg::SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_THR; t++) begin
        v_q[t]   <= '0;
        nk_q[t]  <= '0;
        rel_q[t] <= '0;
        for (int s = 0; s < lka_pkg::SLOTS; s++) begin
          a_q[t][s] <= '0;
          b_q[t][s] <= '0;
        end
      end
    end else begin
      for (int t = 0; t < NUM_THR; t++) begin
        if (ev_thr == TW'(t)) begin
          for (int s = 0; s < lka_pkg::SLOTS; s++) begin
            if (ev_done[s]) begin
              v_q[t][s]  <= 1'b0;
              nk_q[t][s] <= 1'b0;
            end else if (ev_nack[s]) begin
              nk_q[t][s] <= 1'b1;
            end
          end
        end
        if (req_vld[t] && req_rdy[t]) begin
          if (!v_q[t][0]) begin
            v_q[t][0]   <= 1'b1;
            rel_q[t][0] <= req_rel[t];
            a_q[t][0]   <= req_line_a[t*LW +: LW];
            b_q[t][0]   <= req_line_b[t*LW +: LW];
          end else begin
            v_q[t][1]   <= 1'b1;
            rel_q[t][1] <= req_rel[t];
            a_q[t][1]   <= req_line_a[t*LW +: LW];
            b_q[t][1]   <= req_line_b[t*LW +: LW];
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_THR; g++) begin : g_flags
    assign req_rdy[g]   = ~(v_q[g][0] & v_q[g][1]);
    assign thr_stall[g] = nk_q[g][0] | nk_q[g][1];
  end

  assign ev_v   = v_q[ev_thr];
  assign ev_rel = rel_q[ev_thr];
  assign ev_a   = {a_q[ev_thr][1], a_q[ev_thr][0]};
  assign ev_b   = {b_q[ev_thr][1], b_q[ev_thr][0]};

  // R2: a thread whose slots are both taken keeps them unless its window frees one
  a_r2_slot_cap: assert property (@(posedge clk) disable iff (rst)
    (!req_rdy[0] && !(ev_thr == '0 && ev_done != '0)) |=> !req_rdy[0]);
endmodule

// File: rtl/lka_judge.sv
module lka_judge #(
  parameter int NUM_LINES = 64,
  parameter int LW        = 6,
  parameter int TW        = 5
) (
  input  logic [TW-1:0]           thr,
  input  logic [1:0]              v,
  input  logic [1:0]              rel,
  input  logic [2*LW-1:0]         la,
  input  logic [2*LW-1:0]         lb,
  input  logic [NUM_LINES-1:0]    map_q,
  input  logic [NUM_LINES*TW-1:0] own_q,
  output logic [1:0]              ack,
  output logic [1:0]              done,
  output logic [1:0]              nack,
  output logic [1:0]              wen,
  output logic                    bad_rel,
  output logic [NUM_LINES-1:0]    map_nxt
);
  logic [NUM_LINES-1:0] m;
  logic [1:0]           ok;
  logic [LW-1:0]        a, b;
  logic [TW-1:0]        oa, ob;

  always_comb begin
    m       = map_q;
    ok      = '0;
    ack     = '0;
    done    = '0;
    nack    = '0;
    wen     = '0;
    bad_rel = 1'b0;
    a       = '0;
    b       = '0;
    oa      = '0;
    ob      = '0;
    for (int s = 0; s < lka_pkg::SLOTS; s++) begin
      a  = la[s*LW +: LW];
      b  = lb[s*LW +: LW];
      oa = own_q[int'(a)*TW +: TW];
      ob = own_q[int'(b)*TW +: TW];
      if (s == 1 && wen[0]) begin
        if (a == la[LW-1:0] || a == lb[LW-1:0]) oa = thr;
        if (b == la[LW-1:0] || b == lb[LW-1:0]) ob = thr;
      end
      if (rel[s]) ok[s] = m[a] && m[b] && (oa == thr) && (ob == thr);
      else        ok[s] = !m[a] && !m[b];
      ack[s]  = v[s] && ok[s];
      wen[s]  = v[s] && !rel[s] && ok[s];
      done[s] = v[s] && (ok[s] || rel[s]);
      nack[s] = v[s] && !rel[s] && !ok[s];
      if (ack[s]) begin
        m[a] = !rel[s];
        m[b] = !rel[s];
      end
      if (v[s] && rel[s] && !ok[s]) bad_rel = 1'b1;
    end
    map_nxt = m;
  end
endmodule

// File: rtl/lka_registry.sv
module lka_registry #(
  parameter int NUM_LINES = 64,
  parameter int LW        = 6,
  parameter int TW        = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_LINES-1:0]    map_nxt,
  input  logic [1:0]              wen,
  input  logic [2*LW-1:0]         wa,
  input  logic [2*LW-1:0]         wb,
  input  logic [TW-1:0]           wthr,
  output logic [NUM_LINES-1:0]    map_q,
  output logic [NUM_LINES*TW-1:0] own_q
);
  logic [TW-1:0] own_mem [NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) map_q <= '0;
    else     map_q <= map_nxt;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < lka_pkg::SLOTS; s++) begin
      if (wen[s]) begin
        own_mem[wa[s*LW +: LW]] <= wthr;
        own_mem[wb[s*LW +: LW]] <= wthr;
      end
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_own
    assign own_q[g*TW +: TW] = own_mem[g];
  end

  // R5: a slot-1 grant leaves both of its lines locked after the edge
  a_r5_grant_sets: assert property (@(posedge clk) disable iff (rst)
    wen[1] |=> (map_q[$past(wa[2*LW-1:LW])] && map_q[$past(wb[2*LW-1:LW])]));
endmodule

// File: rtl/rr_lock_arbiter.sv
module rr_lock_arbiter #(
  parameter int NUM_CORES    = 16,
  parameter int THR_PER_CORE = 2,
  parameter int NUM_LINES    = 64,
  localparam int NUM_THR     = NUM_CORES * THR_PER_CORE,
  localparam int TW          = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int LW          = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_THR-1:0]    req_vld,
  input  logic [NUM_THR-1:0]    req_rel,
  input  logic [NUM_THR*LW-1:0] req_line_a,
  input  logic [NUM_THR*LW-1:0] req_line_b,
  output logic [NUM_THR-1:0]    req_rdy,
  output logic [NUM_THR-1:0]    thr_stall,
  output logic [1:0]            rsp_vld,
  output logic [1:0]            rsp_ack,
  output logic [TW-1:0]         rsp_thr,
  output logic                  err_rel
);
  logic [TW-1:0]           ptr;
  logic [1:0]              ev_v, ev_rel, ack, done, nack, wen;
  logic [2*LW-1:0]         ev_a, ev_b;
  logic [NUM_LINES-1:0]    map_q, map_nxt;
  logic [NUM_LINES*TW-1:0] own_q;
  logic                    bad_rel;
  logic [1:0]              rsp_lk;

  lka_slots #(.NUM_THR(NUM_THR), .LW(LW), .TW(TW)) u_slots (
    .clk(clk), .rst(rst),
    .req_vld(req_vld), .req_rel(req_rel),
    .req_line_a(req_line_a), .req_line_b(req_line_b),
    .ev_thr(ptr), .ev_done(done), .ev_nack(nack),
    .req_rdy(req_rdy), .thr_stall(thr_stall),
    .ev_v(ev_v), .ev_rel(ev_rel), .ev_a(ev_a), .ev_b(ev_b)
  );

  lka_judge #(.NUM_LINES(NUM_LINES), .LW(LW), .TW(TW)) u_judge (
    .thr(ptr), .v(ev_v), .rel(ev_rel), .la(ev_a), .lb(ev_b),
    .map_q(map_q), .own_q(own_q),
    .ack(ack), .done(done), .nack(nack), .wen(wen),
    .bad_rel(bad_rel), .map_nxt(map_nxt)
  );

  lka_registry #(.NUM_LINES(NUM_LINES), .LW(LW), .TW(TW)) u_reg (
    .clk(clk), .rst(rst), .map_nxt(map_nxt), .wen(wen),
    .wa(ev_a), .wb(ev_b), .wthr(ptr),
    .map_q(map_q), .own_q(own_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      rsp_vld <= '0;
      rsp_ack <= '0;
      rsp_lk  <= '0;
      rsp_thr <= '0;
      err_rel <= 1'b0;
    end else begin
      ptr     <= TW'(lka_pkg::wrap_next(int'(ptr), NUM_THR));
      rsp_vld <= ev_v;
      rsp_ack <= ack;
      rsp_lk  <= ev_v & ~ev_rel;
      rsp_thr <= ptr;
      err_rel <= err_rel | bad_rel;
    end
  end

  // R3: responses in consecutive cycles come from consecutive threads
  a_r3_rotate: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld != '0 && $past(rsp_vld) != '0)
      |-> rsp_thr == TW'(lka_pkg::wrap_next(int'($past(rsp_thr)), NUM_THR)));

  // R6: a refused lock leaves its thread stalled
  a_r6_nack_stalls: assert property (@(posedge clk) disable iff (rst)
    ((rsp_vld[0] && !rsp_ack[0] && rsp_lk[0]) || (rsp_vld[1] && !rsp_ack[1] && rsp_lk[1]))
      |-> thr_stall[rsp_thr]);

  // R9: the release error flag never drops without reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(err_rel) |-> err_rel);
endmodule

// File: tb/rr_lock_arbiter_tb.sv
`timescale 1ns/1ps
module rr_lock_arbiter_tb;
  localparam int NT = 32;
  localparam int LW = 6;
  localparam int TW = 5;

  typedef struct { int s; int ack; string tag; } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0]    req_vld = '0, req_rel = '0;
  logic [NT*LW-1:0] req_a = '0, req_b = '0;
  logic [NT-1:0]    req_rdy, thr_stall;
  logic [1:0]       rsp_vld, rsp_ack;
  logic [TW-1:0]    rsp_thr;
  logic             err_rel;

  int   n_chk = 0, n_bad = 0, cyc = 0, mt, ma, lat;
  exp_t q_exp [NT][$];
  logic [1:0] last_nack [NT];

  always #4 clk = ~clk;

  rr_lock_arbiter u_dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_rel(req_rel),
    .req_line_a(req_a), .req_line_b(req_b), .req_rdy(req_rdy),
    .thr_stall(thr_stall), .rsp_vld(rsp_vld), .rsp_ack(rsp_ack),
    .rsp_thr(rsp_thr), .err_rel(err_rel)
  );

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected answers per thread; repeated NACKs are retries
  always @(negedge clk) if (!rst) begin
    if (rsp_vld != 2'b00)
      chk(int'(rsp_thr) == (cyc - 1) % NT, "R3 rotation thread", int'(rsp_thr), (cyc - 1) % NT);
    for (int s = 0; s < 2; s++) if (rsp_vld[s]) begin
      mt = int'(rsp_thr);
      ma = int'(rsp_ack[s]);
      if (q_exp[mt].size() > 0 && q_exp[mt][0].s == s && q_exp[mt][0].ack == ma) begin
        chk(1'b1, q_exp[mt][0].tag, ma, ma);
        last_nack[mt][s] = (ma == 0);
        void'(q_exp[mt].pop_front());
      end else if (ma == 0 && last_nack[mt][s]) begin
      end else begin
        chk(1'b0, (q_exp[mt].size() > 0) ? q_exp[mt][0].tag : "R4 unexpected response",
            mt * 10 + s * 2 + ma,
            (q_exp[mt].size() > 0) ? mt * 10 + q_exp[mt][0].s * 2 + q_exp[mt][0].ack : -1);
      end
    end
  end

  task automatic put(int t, bit rel, int a, int b);
    req_vld[t] = 1'b1;
    req_rel[t] = rel;
    req_a[t*LW +: LW] = LW'(a);
    req_b[t*LW +: LW] = LW'(b);
  endtask

  task automatic expect_rsp(int t, int s, int ack, string tag);
    exp_t e;
    e.s = s; e.ack = ack; e.tag = tag;
    q_exp[t].push_back(e);
  endtask

  task automatic fire();
    @(negedge clk);
    req_vld = '0;
  endtask

  task automatic settle(string tag);
    int left;
    repeat (2 * NT + 6) @(negedge clk);
    left = 0;
    for (int t = 0; t < NT; t++) left += q_exp[t].size();
    chk(left == 0, tag, left, 0);
  endtask

  task automatic wait_ptr(int p);
    do @(negedge clk); while (cyc % NT != p);
  endtask

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) last_nack[t] = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(rsp_vld == 2'b00, "R1 rsp_vld", int'(rsp_vld), 0);
    chk(req_rdy == '1, "R1 req_rdy", int'(req_rdy == '1), 1);
    chk(thr_stall == '0, "R1 thr_stall", int'(thr_stall != '0), 0);
    chk(err_rel == 1'b0, "R1 err_rel", int'(err_rel), 0);

    // R5 + R10: lone lock
    put(3, 0, 1, 2); expect_rsp(3, 0, 1, "R5 lone lock ACK");
    fire();
    lat = 0;
    do begin @(negedge clk); lat++; end while (rsp_vld == 2'b00 && lat < 200);
    chk(lat <= NT, "R10 lone latency", lat, NT);
    settle("R5 queue drained");

    // R6: overlap refused, stall raised
    put(9, 0, 2, 5); expect_rsp(9, 0, 0, "R6 overlap NACK");
    fire(); settle("R6 queue drained");
    chk(thr_stall[9] == 1'b1, "R6 stall after NACK", int'(thr_stall[9]), 1);
    chk(req_rdy[9] == 1'b1, "R2 one slot still free", int'(req_rdy[9]), 1);
    // R6 no partial grant: line 5 still free
    put(12, 0, 5, 9); expect_rsp(12, 0, 1, "R6 no partial set");
    fire(); settle("R6 partial drained");
    // R4: slot 1 served although slot 0 refused
    put(9, 0, 6, 7); expect_rsp(9, 1, 1, "R4 slot1 ACK behind slot0");
    fire(); settle("R4 drained");
    put(9, 0, 5, 8); expect_rsp(9, 1, 0, "R6 slot1 NACK");
    fire(); settle("R6 slot1 drained");
    chk(req_rdy[9] == 1'b0, "R2 both slots taken", int'(req_rdy[9]), 0);
    // R2: offer while full is not taken
    put(9, 0, 20, 21); fire(); settle("R2 refused offer");
    put(4, 0, 20, 21); expect_rsp(4, 0, 1, "R2 ignored offer left lines free");
    fire(); settle("R2 drained");
    put(4, 1, 20, 21); expect_rsp(4, 0, 1, "R8 release ACK");
    fire(); settle("R8 drained");

    // R9: release of lines held by another thread
    put(7, 1, 1, 2); expect_rsp(7, 0, 0, "R9 foreign release NACK");
    fire(); settle("R9 drained");
    chk(err_rel == 1'b1, "R9 err set", int'(err_rel), 1);
    put(3, 1, 1, 2); expect_rsp(3, 0, 1, "R9 lines still held by owner");
    fire(); settle("R8 owner release drained");
    chk(thr_stall[9] == 1'b1, "R6 still stalled", int'(thr_stall[9]), 1);
    // R4 chained: slot0 grant blocks slot1 in the same window
    put(12, 1, 5, 9); expect_rsp(12, 0, 1, "R8 release 12");
    expect_rsp(9, 0, 1, "R6 retry granted"); expect_rsp(9, 1, 0, "R4 slot1 sees slot0 grant");
    fire(); settle("R4 chain drained");
    put(9, 1, 2, 5); expect_rsp(9, 0, 1, "R8 release slot0");
    expect_rsp(9, 1, 1, "R4 slot1 sees slot0 release");
    fire(); settle("R4 release chain drained");
    put(9, 1, 6, 7); expect_rsp(9, 0, 1, "R8 release 6/7");
    fire();
    put(9, 1, 5, 8); expect_rsp(9, 1, 1, "R8 release 5/8");
    fire(); settle("R8 thread 9 drained");
    chk(thr_stall[9] == 1'b0, "R6 stall cleared", int'(thr_stall[9]), 0);
    chk(err_rel == 1'b1, "R9 err sticky", int'(err_rel), 1);

    // R7: next-cycle window sees previous grant
    wait_ptr(12);
    put(10, 0, 40, 41); put(11, 0, 41, 42);
    expect_rsp(10, 0, 1, "R7 first ACK"); expect_rsp(11, 0, 0, "R7 next cycle NACK");
    fire(); settle("R7 drained");
    put(10, 1, 40, 41); expect_rsp(10, 0, 1, "R8 release 10");
    expect_rsp(11, 0, 1, "R6 retry after release");
    fire(); settle("R7 retry drained");
    put(11, 1, 41, 42); expect_rsp(11, 0, 1, "R8 release 11");
    fire(); settle("R8 11 drained");

    // R3: full sweep, every thread once in order
    for (int t = 0; t < NT; t++) begin
      put(t, 0, 2 * t, 2 * t + 1); expect_rsp(t, 0, 1, "R3 sweep lock");
    end
    fire(); settle("R3 sweep drained");
    for (int t = 0; t < NT; t++) begin
      put(t, 1, 2 * t, 2 * t + 1); expect_rsp(t, 0, 1, "R3 sweep release");
    end
    fire(); settle("R3 release drained");
    // R5: equal lines
    put(0, 0, 50, 50); expect_rsp(0, 0, 1, "R5 single-line lock");
    fire(); settle("R5 single drained");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule